// File: doc/BRIEF.md
# I2C Target Interface with Register Port

This block lets a chip answer as a target on a two-wire I2C bus at a single 7-bit address. A controller on the bus can write bytes to it or read bytes from it. Local software runs each byte through a small register port. Address matches, received bytes, a free transmit slot, finished transmit bytes, STOP conditions and general-call hits are latched as status flags. Each flag can drive a level interrupt through its own enable bit.

The block takes its SCL and SDA samples through synchronisers. It pulls the lines low only through two open-drain enables. After the acknowledge slot of every byte that software must handle, it holds SCL low, so the controller waits as long as software needs. Software releases the bus by clearing the flag for that byte. In a read, software must also load the next byte to send. A control bit makes the target NACK incoming data bytes.

Top module: `i2c_target_regif`

## Requirements
- R1: After reset every status bit reads 0, irq is low, and both scl_oe and sda_oe are low. The register address map is: control = 0, status = 1, interrupt enable = 2, own address = 3, data = 4.
- R2: When the control enable bit is set, the target matches a bus address byte whose upper seven bits equal the own-address register. For a match it pulls SDA low in the acknowledge slot, sets status bit 0 and shows the read/write bit of the address byte in status bit 5. Any other address gets no acknowledge and changes no flag.
- R3: Writing the status register clears every flag whose written bit is 0 and leaves every flag whose written bit is 1 unchanged.
- R4: irq is high exactly when some status bit and the same bit of the interrupt-enable register are both 1.
- R5: After the acknowledge slot of an address byte or an acknowledged data byte, the target holds SCL low (scl_oe high) until software has cleared the flag that requires service.
- R6: In a write transfer, each data byte arrives MSB first. The byte is acknowledged, sets status bit 1 and can be read from the data register.
- R7: While control bit 0 is set, the next received data byte is answered with NACK, and the target does not stretch SCL after that byte.
- R8: In a read transfer, status bit 3 is set whenever the data register can take the next byte. SCL stays held until the data register has been written. Bytes leave MSB first, and status bit 2 is set after each byte is sent. A NACK from the controller ends the transfer without stretching.
- R9: A STOP seen after this target was addressed sets status bit 4, clears status bit 5 and releases both lines. A STOP without an address match sets no flag.
- R10: Address byte 0x00 with the write bit is acknowledged only when control bit 1 is set, and it then sets status bits 6 and 0. With control bit 1 clear it gets no acknowledge.
- R11: With control bit 2 clear, the target ignores the bus: it never acknowledges and never drives SCL or SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select for reads and writes |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Level interrupt |

## Verification
If the byte engine's state goes wrong, the acknowledge slot shows it on the bus one bit period later: either the bit is missing, or SDA is pulled low for an address that does not match. A lost or stuck service flag shows up as SCL that is never released, or never held, within a few cycles of the acknowledge slot ending. A wrong bit counter shifts the received or transmitted byte, and the data register or the controller's sampled byte shows this by the end of that byte. Stale flag storage shows up when the status register is read back and in the irq level, which is compared against status and enable on every clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int RA_W = 3;
  localparam int AW = 7;

  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_STAT = 3'd1;
  localparam logic [RA_W-1:0] RA_IEN  = 3'd2;
  localparam logic [RA_W-1:0] RA_OWN  = 3'd3;
  localparam logic [RA_W-1:0] RA_DATA = 3'd4;

  // control bit positions
  localparam int CB_FNACK = 0;
  localparam int CB_GCEN  = 1;
  localparam int CB_EN    = 2;

  // status bit positions
  localparam int SB_ADR  = 0;
  localparam int SB_RX   = 1;
  localparam int SB_TXD  = 2;
  localparam int SB_EMP  = 3;
  localparam int SB_STOP = 4;
  localparam int SB_DIR  = 5;
  localparam int SB_GC   = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_HOLD, S_RX, S_RACK, S_TX, S_TACK, S_WAIT
  } eng_state_e;

  function automatic logic is_gc_frame(logic [7:0] frame);
    return frame[7:1] == '0;
  endfunction

  // does an address frame select this target
  function automatic logic frame_hit(logic [7:0] frame, logic [AW-1:0] own, logic gcen);
    if (is_gc_frame(frame)) return gcen && !frame[0];
    return frame[7:1] == own;
  endfunction
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          gcen,
  input  logic          fnack,
  input  logic [AW-1:0] own,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          adr_flag,
  input  logic          rx_flag,
  input  logic          tx_full,
  input  logic [7:0]    tx_byte,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          ev_adr,
  output logic          ev_gc,
  output logic          ev_rx,
  output logic          ev_txd,
  output logic          ev_emp,
  output logic          ev_stop,
  output logic          tx_take,
  output logic [7:0]    rx_byte,
  output logic          dir_tx
);
  eng_state_e st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, sel, nack_q, ack_q;
  logic       hold_done;

  assign hold_done = !adr_flag && (rw ? tx_full : !rx_flag);
  assign dir_tx    = sel & rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; sel <= 1'b0;
      nack_q <= 1'b0; ack_q <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      ev_adr <= 1'b0; ev_gc <= 1'b0; ev_rx <= 1'b0; ev_txd <= 1'b0;
      ev_emp <= 1'b0; ev_stop <= 1'b0; tx_take <= 1'b0; rx_byte <= '0;
    end else begin
      ev_adr <= 1'b0; ev_gc <= 1'b0; ev_rx <= 1'b0; ev_txd <= 1'b0;
      ev_emp <= 1'b0; ev_stop <= 1'b0; tx_take <= 1'b0;
      if (!en) begin
        st <= S_IDLE; sel <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        ev_stop <= sel;
        st <= S_IDLE; sel <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else if (start_evt) begin
        st <= S_ADDR; cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (frame_hit(sh, own, gcen)) begin
                sel <= 1'b1; rw <= sh[0]; sda_oe <= 1'b1;
                ev_adr <= 1'b1; ev_gc <= is_gc_frame(sh);
                ev_emp <= sh[0] && !tx_full;
                st <= S_AACK;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            sda_oe <= 1'b0; scl_oe <= 1'b1; st <= S_HOLD;
          end
          S_HOLD: if (hold_done) begin
            scl_oe <= 1'b0; cnt <= '0;
            if (rw) begin
              sh <= tx_byte; sda_oe <= ~tx_byte[7];
              tx_take <= 1'b1; ev_emp <= 1'b1; st <= S_TX;
            end else begin
              st <= S_RX;
            end
          end
          S_RX: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              rx_byte <= sh; ev_rx <= 1'b1;
              sda_oe <= ~fnack; nack_q <= fnack; st <= S_RACK;
            end
          end
          S_RACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0;
            if (nack_q) st <= S_WAIT;
            else begin scl_oe <= 1'b1; st <= S_HOLD; end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= S_TACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              ack_q <= ~sda_s; ev_txd <= 1'b1;
            end else if (scl_fall) begin
              if (ack_q) begin scl_oe <= 1'b1; st <= S_HOLD; end
              else st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  stretch_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> sel);
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && en) |=> (!scl_oe && !sda_oe));
  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe && !sel));
  // R8
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_full);
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] ra,
  input  logic            we,
  input  logic [7:0]      wd,
  output logic [7:0]      rd,
  input  logic            ev_adr,
  input  logic            ev_gc,
  input  logic            ev_rx,
  input  logic            ev_txd,
  input  logic            ev_emp,
  input  logic            ev_stop,
  input  logic            tx_take,
  input  logic            dir_tx,
  input  logic [7:0]      rx_byte,
  output logic            en,
  output logic            gcen,
  output logic            fnack,
  output logic [AW-1:0]   own,
  output logic [7:0]      tx_byte,
  output logic            tx_full,
  output logic            adr_flag,
  output logic            rx_flag,
  output logic            irq
);
  logic [3:0] ctrl;
  logic [6:0] ien, fl, set_v, keep_v, stat_v;
  logic [7:0] rx_q;
  logic       ctrl_wr, stat_wr, ien_wr, own_wr, data_wr;

  assign ctrl_wr = we && ra == RA_CTRL;
  assign stat_wr = we && ra == RA_STAT;
  assign ien_wr  = we && ra == RA_IEN;
  assign own_wr  = we && ra == RA_OWN;
  assign data_wr = we && ra == RA_DATA;

  always_comb begin
    set_v = '0;
    set_v[SB_ADR]  = ev_adr;
    set_v[SB_RX]   = ev_rx;
    set_v[SB_TXD]  = ev_txd;
    set_v[SB_EMP]  = ev_emp;
    set_v[SB_STOP] = ev_stop;
    set_v[SB_GC]   = ev_gc;
    keep_v = stat_wr ? wd[6:0] : '1;
    if (data_wr) keep_v[SB_EMP] = 1'b0;
    keep_v[SB_DIR] = 1'b0;
    stat_v = fl;
    stat_v[SB_DIR] = dir_tx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; ien <= '0; fl <= '0; own <= '0;
      rx_q <= '0; tx_byte <= '0; tx_full <= 1'b0;
    end else begin
      fl <= (fl & keep_v) | set_v;
      if (ctrl_wr) ctrl <= wd[3:0];
      if (ien_wr)  ien  <= wd[6:0];
      if (own_wr)  own  <= wd[AW-1:0];
      if (ev_rx)   rx_q <= rx_byte;
      if (data_wr) begin
        tx_byte <= wd; tx_full <= 1'b1;
      end else if (tx_take) begin
        tx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    case (ra)
      RA_CTRL: rd = {4'b0, ctrl};
      RA_STAT: rd = {1'b0, stat_v};
      RA_IEN:  rd = {1'b0, ien};
      RA_OWN:  rd = {1'b0, own};
      RA_DATA: rd = rx_q;
      default: rd = '0;
    endcase
  end

  assign en       = ctrl[CB_EN];
  assign gcen     = ctrl[CB_GCEN];
  assign fnack    = ctrl[CB_FNACK];
  assign adr_flag = fl[SB_ADR];
  assign rx_flag  = fl[SB_RX];
  assign irq      = |(stat_v & ien);

  // R3
  adr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wd[SB_ADR] && !ev_adr) |=> !adr_flag);
endmodule

// File: rtl/i2c_target_regif.sv
module i2c_target_regif
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] reg_addr,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            irq
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic en, gcen, fnack, tx_full, adr_flag, rx_flag, dir_tx, tx_take;
  logic ev_adr, ev_gc, ev_rx, ev_txd, ev_emp, ev_stop;
  logic [AW-1:0] own;
  logic [7:0] tx_byte, rx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_tgt_engine u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .gcen(gcen), .fnack(fnack), .own(own),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .adr_flag(adr_flag), .rx_flag(rx_flag), .tx_full(tx_full), .tx_byte(tx_byte),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ev_adr(ev_adr), .ev_gc(ev_gc), .ev_rx(ev_rx), .ev_txd(ev_txd),
    .ev_emp(ev_emp), .ev_stop(ev_stop), .tx_take(tx_take),
    .rx_byte(rx_byte), .dir_tx(dir_tx)
  );

  i2c_tgt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ra(reg_addr), .we(reg_we), .wd(reg_wdata),
    .rd(reg_rdata),
    .ev_adr(ev_adr), .ev_gc(ev_gc), .ev_rx(ev_rx), .ev_txd(ev_txd),
    .ev_emp(ev_emp), .ev_stop(ev_stop), .tx_take(tx_take), .dir_tx(dir_tx),
    .rx_byte(rx_byte), .en(en), .gcen(gcen), .fnack(fnack), .own(own),
    .tx_byte(tx_byte), .tx_full(tx_full), .adr_flag(adr_flag),
    .rx_flag(rx_flag), .irq(irq)
  );
endmodule

// File: tb/i2c_target_regif_bench.sv
module i2c_target_regif_bench;
  localparam int HALF = 8;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2,
                         A_OWN = 3'd3, A_DATA = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = A_STAT;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] ien_m = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wire scl_ln = m_scl & ~scl_oe;
  wire sda_ln = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_target_regif u_i2c_target_regif (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_i(scl_ln), .sda_i(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // R4 per-clock comparison of irq against status and the modelled enable
  always @(posedge clk) begin
    #5;
    if (rst_n && !done && !reg_we && reg_addr == A_STAT)
      chk("R4", "irq vs status&enable", int'(irq), int'(|(reg_rdata[6:0] & ien_m)));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0; reg_addr = A_STAT;
    if (a == A_IEN) ien_m = d[6:0];
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata; reg_addr = A_STAT;
  endtask

  task automatic chk_stat(input string req, input int exp);
    logic [7:0] v;
    reg_rd(A_STAT, v);
    chk(req, "status", int'(v), exp);
  endtask

  task automatic wait_scl_high();
    while (!scl_ln) @(negedge clk);
  endtask

  task automatic bus_start();
    m_scl = 1'b1; m_sda = 1'b1; cyc(HALF);
    m_sda = 1'b0; cyc(HALF);
    m_scl = 1'b0; cyc(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(HALF);
    m_scl = 1'b1; wait_scl_high(); cyc(HALF);
    m_sda = 1'b1; cyc(HALF);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; cyc(HALF);
    m_scl = 1'b1; wait_scl_high(); cyc(HALF);
    s = sda_ln; m_scl = 1'b0; cyc(HALF);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~ack, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    cyc(3); rst_n = 1'b1; cyc(2);
    // R1 reset state
    chk_stat("R1", 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "scl_oe", int'(scl_oe), 0);
    chk("R1", "sda_oe", int'(sda_oe), 0);

    reg_wr(A_OWN, 8'h2A);
    reg_wr(A_IEN, 8'h7F);
    reg_wr(A_CTRL, 8'h04);

    // write transfer
    bus_start();
    wr_byte(8'h54, ack);
    chk("R2", "address ack", int'(ack), 1);
    chk_stat("R2", 8'h01);
    chk("R4", "irq on address", int'(irq), 1);
    chk("R5", "stretch after address", int'(scl_oe), 1);
    cyc(20);
    chk("R5", "still stretched", int'(scl_oe), 1);
    reg_wr(A_STAT, 8'hFE);
    chk_stat("R3", 0);
    cyc(3);
    chk("R5", "released after clear", int'(scl_oe), 0);
    wr_byte(8'hA5, ack);
    chk("R6", "data ack", int'(ack), 1);
    chk_stat("R6", 8'h02);
    reg_rd(A_DATA, d);
    chk("R6", "received byte", int'(d), 8'hA5);
    chk("R5", "stretch after data", int'(scl_oe), 1);
    reg_wr(A_STAT, 8'hFF);
    chk_stat("R3", 8'h02);
    reg_wr(A_STAT, 8'hFD);
    wr_byte(8'h3C, ack);
    chk("R6", "second ack", int'(ack), 1);
    reg_rd(A_DATA, d);
    chk("R6", "second byte", int'(d), 8'h3C);
    reg_wr(A_CTRL, 8'h05);
    reg_wr(A_STAT, 8'hFD);
    wr_byte(8'h77, ack);
    chk("R7", "forced nack", int'(ack), 0);
    chk_stat("R7", 8'h02);
    chk("R7", "no stretch after nack", int'(scl_oe), 0);
    reg_wr(A_STAT, 8'h00);
    reg_wr(A_CTRL, 8'h04);
    bus_stop();
    chk_stat("R9", 8'h10);
    reg_wr(A_IEN, 8'h00);
    chk("R4", "irq masked", int'(irq), 0);
    reg_wr(A_IEN, 8'h10);
    chk("R4", "irq stop enabled", int'(irq), 1);
    reg_wr(A_STAT, 8'hEF);
    reg_wr(A_IEN, 8'h7F);
    chk_stat("R3", 0);

    // foreign address
    bus_start();
    wr_byte(8'h56, ack);
    chk("R2", "foreign address nack", int'(ack), 0);
    chk("R2", "no stretch on foreign", int'(scl_oe), 0);
    bus_stop();
    chk_stat("R9", 0);

    // read transfer
    bus_start();
    wr_byte(8'h55, ack);
    chk("R2", "read address ack", int'(ack), 1);
    chk_stat("R8", 8'h29);
    reg_wr(A_STAT, 8'hFE);
    cyc(10);
    chk("R8", "held without data", int'(scl_oe), 1);
    reg_wr(A_DATA, 8'hC3);
    cyc(3);
    chk("R8", "released after data", int'(scl_oe), 0);
    chk_stat("R8", 8'h28);
    rd_byte(1'b1, d);
    chk("R8", "first read byte", int'(d), 8'hC3);
    chk_stat("R8", 8'h2C);
    chk("R8", "held for next byte", int'(scl_oe), 1);
    reg_wr(A_DATA, 8'h5A);
    rd_byte(1'b0, d);
    chk("R8", "second read byte", int'(d), 8'h5A);
    chk("R8", "no stretch after controller nack", int'(scl_oe), 0);
    bus_stop();
    chk_stat("R9", 8'h1C);
    reg_wr(A_STAT, 8'h00);

    // general call
    bus_start();
    wr_byte(8'h00, ack);
    chk("R10", "general call disabled nack", int'(ack), 0);
    bus_stop();
    chk_stat("R10", 0);
    reg_wr(A_CTRL, 8'h06);
    bus_start();
    wr_byte(8'h00, ack);
    chk("R10", "general call ack", int'(ack), 1);
    chk_stat("R10", 8'h41);
    reg_wr(A_STAT, 8'hBE);
    wr_byte(8'h11, ack);
    reg_rd(A_DATA, d);
    chk("R10", "general call data", int'(d), 8'h11);
    reg_wr(A_STAT, 8'hFD);
    bus_stop();
    chk_stat("R9", 8'h10);
    reg_wr(A_STAT, 8'h00);

    // disabled target
    reg_wr(A_CTRL, 8'h00);
    bus_start();
    wr_byte(8'h54, ack);
    chk("R11", "disabled nack", int'(ack), 0);
    chk("R11", "disabled scl", int'(scl_oe), 0);
    bus_stop();
    chk_stat("R11", 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule